// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the data-processing core of a simple integer datapath. Each cycle the surrounding pipeline presents a 4-bit operation code, two operands and the current condition flags. The block returns a result, a strobe saying whether the result belongs in the destination register, and the next values of the negative (N), zero (Z), carry (C) and overflow (V) flags. The second operand arrives already shifted. The carry bit the shifter produced comes in on its own pin, so logical operations can report it as their carry.

The unit is purely combinational. It supports sixteen operations: six logical ones, six arithmetic ones (three of them consume the carry flag), and four compare forms that only update flags. All add and subtract forms share one adder. Subtraction is done by inverting one operand and feeding the carry input, so C is the unsigned carry for additions and means "no borrow" for subtractions. A parameter chooses between a behavioural adder and an explicit ripple-carry chain.

Top module: `flag_alu`

## Requirements
- R1: Logical operations produce AND (code 0000), XOR (0001), OR (1100), A AND NOT B (1110), pass B (1101) and NOT B (1111). Each of them drives result_we high.
- R2: ADD (0100) gives A+B, SUB (0010) gives A-B and reverse subtract (0011) gives B-A, all modulo 2^WIDTH.
- R3: Add-with-carry (0101) gives A+B+C. Subtract-with-carry (0110) gives A-B-(1-C). Reverse-subtract-with-carry (0111) gives B-A-(1-C). C is the flag_c_in pin.
- R4: The compare codes 1000, 1001, 1010 and 1011 compute AND, XOR, A-B and A+B respectively. They hold result_we low and update the flags even when set_flags is low.
- R5: When flags update, flag_n_out equals result bit WIDTH-1, and flag_z_out is high exactly when the result is all zeros.
- R6: When an arithmetic operation updates flags, flag_c_out is the carry out of the top bit for add forms and the inverse of the borrow for subtract forms.
- R7: When an arithmetic operation updates flags, flag_v_out is high exactly when signed overflow occurs.
- R8: When a logical operation updates flags, flag_c_out equals shift_carry and flag_v_out equals flag_v_in.
- R9: When set_flags is low and the code is not a compare, all four flag outputs equal their inputs and result_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand, already shifted |
| flag_n_in | input | 1 | Current negative flag |
| flag_z_in | input | 1 | Current zero flag |
| flag_c_in | input | 1 | Current carry flag |
| flag_v_in | input | 1 | Current overflow flag |
| shift_carry | input | 1 | Carry produced by the operand shifter |
| set_flags | input | 1 | Request to update flags |
| result | output | WIDTH | Operation result |
| result_we | output | 1 | Result should be written back |
| flag_n_out | output | 1 | Next negative flag |
| flag_z_out | output | 1 | Next zero flag |
| flag_c_out | output | 1 | Next carry flag |
| flag_v_out | output | 1 | Next overflow flag |

## Verification
The immediate assertions evaluate the settled combinational outputs. They assume every input is a known 0 or 1, because an unknown operation code would make the decode checks meaningless. The bench therefore drives all inputs to defined values before the first check and changes them only on the falling clock edge. It samples the outputs one nanosecond later, once the logic has settled.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'b0000,
      OP_XOR = 4'b0001,
      OP_SUB = 4'b0010,
      OP_RSB = 4'b0011,
      OP_ADD = 4'b0100,
      OP_ADC = 4'b0101,
      OP_SBC = 4'b0110,
      OP_RSC = 4'b0111,
      OP_TAND = 4'b1000,
      OP_TXOR = 4'b1001,
      OP_CSUB = 4'b1010,
      OP_CADD = 4'b1011,
      OP_OR  = 4'b1100,
      OP_PASS = 4'b1101,
      OP_CLR = 4'b1110,
      OP_NOT = 4'b1111
   } alu_op_e;

   typedef struct packed {
      logic compare;
      logic arith;
   } op_class_t;

   function automatic op_class_t classify(input alu_op_e op);
      op_class_t k;
      k.compare = (op[3:2] == 2'b10);
      case (op)
         OP_SUB, OP_RSB, OP_ADD, OP_ADC,
         OP_SBC, OP_RSC, OP_CSUB, OP_CADD: k.arith = 1'b1;
         default:                          k.arith = 1'b0;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  alu_op_e           op,
   input  logic [WIDTH-1:0]  a,
   input  logic [WIDTH-1:0]  b,
   output logic [WIDTH-1:0]  y
);

   always_comb begin
      case (op)
         OP_AND, OP_TAND: y = a & b;
         OP_XOR, OP_TXOR: y = a ^ b;
         OP_OR:           y = a | b;
         OP_PASS:         y = b;
         OP_CLR:          y = a & ~b;
         OP_NOT:          y = ~b;
         default:         y = '0;
      endcase
   end

   always_comb begin
      if (op == OP_PASS)
         a_r1_pass_is_b: assert (y == b);
      if (op == OP_NOT)
         a_r1_not_inverts: assert ((y ^ b) == {WIDTH{1'b1}});
   end

endmodule

// File: rtl/alu_add_unit.sv
module alu_add_unit
   import alu_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter int ADDER_STYLE  = 0
) (
   input  alu_op_e           op,
   input  logic [WIDTH-1:0]  a,
   input  logic [WIDTH-1:0]  b,
   input  logic              c_in,
   output logic [WIDTH-1:0]  sum,
   output logic              c_out,
   output logic              ovf
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] x, z;
   logic             cin;

   // Operand steering: subtraction is x + ~z + carry
   always_comb begin
      case (op)
         OP_SUB, OP_CSUB: begin x = a; z = ~b; cin = 1'b1; end
         OP_RSB:          begin x = b; z = ~a; cin = 1'b1; end
         OP_ADC:          begin x = a; z = b;  cin = c_in; end
         OP_SBC:          begin x = a; z = ~b; cin = c_in; end
         OP_RSC:          begin x = b; z = ~a; cin = c_in; end
         default:         begin x = a; z = b;  cin = 1'b0; end
      endcase
   end

   generate
      if (ADDER_STYLE == 0) begin : g_behav
         logic [WIDTH:0] wide;
         assign wide  = {1'b0, x} + {1'b0, z} + {{WIDTH{1'b0}}, cin};
         assign sum   = wide[MSB:0];
         assign c_out = wide[WIDTH];
         assign ovf   = (x[MSB] == z[MSB]) && (sum[MSB] != x[MSB]);
      end else begin : g_ripple
         logic [WIDTH:0] cc;
         assign cc[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = x[i] ^ z[i] ^ cc[i];
            assign cc[i+1] = (x[i] & z[i]) | (cc[i] & (x[i] ^ z[i]));
         end
         assign c_out = cc[WIDTH];
         assign ovf   = cc[WIDTH] ^ cc[MSB];
      end
   endgenerate

   always_comb begin
      if ((op == OP_ADD) && !a[MSB] && !b[MSB])
         a_r7_pos_add_no_carry: assert (!c_out);
   end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] res,
   input  logic             update,
   input  logic             arith,
   input  logic             add_carry,
   input  logic             add_ovf,
   input  logic             shift_carry,
   input  logic             n_in,
   input  logic             z_in,
   input  logic             c_in,
   input  logic             v_in,
   output logic             n_out,
   output logic             z_out,
   output logic             c_out,
   output logic             v_out
);

   always_comb begin
      n_out = n_in;
      z_out = z_in;
      c_out = c_in;
      v_out = v_in;
      if (update) begin
         n_out = res[WIDTH-1];
         z_out = (res == '0);
         c_out = arith ? add_carry : shift_carry;
         if (arith)
            v_out = add_ovf;
      end
   end

   always_comb begin
      if (update && !arith)
         a_r8_logic_keeps_v: assert (v_out == v_in);
      if (!update)
         a_r9_hold_flags: assert ({n_out, z_out, c_out, v_out} == {n_in, z_in, c_in, v_in});
   end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import alu_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = 0
) (
   input  logic [3:0]        op_code,
   input  logic [WIDTH-1:0]  opnd_a,
   input  logic [WIDTH-1:0]  opnd_b,
   input  logic              flag_n_in,
   input  logic              flag_z_in,
   input  logic              flag_c_in,
   input  logic              flag_v_in,
   input  logic              shift_carry,
   input  logic              set_flags,
   output logic [WIDTH-1:0]  result,
   output logic              result_we,
   output logic              flag_n_out,
   output logic              flag_z_out,
   output logic              flag_c_out,
   output logic              flag_v_out
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("flag_alu: WIDTH must be at least 2");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("flag_alu: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   alu_op_e          op;
   op_class_t        kind;
   logic [WIDTH-1:0] logic_y, add_y;
   logic             add_c, add_v, upd;

   assign op   = alu_op_e'(op_code);
   assign kind = classify(op);
   assign upd  = set_flags | kind.compare;

   alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
      .op (op),
      .a  (opnd_a),
      .b  (opnd_b),
      .y  (logic_y)
   );

   alu_add_unit #(.WIDTH(WIDTH), .ADDER_STYLE(ADDER_STYLE)) u_add (
      .op    (op),
      .a     (opnd_a),
      .b     (opnd_b),
      .c_in  (flag_c_in),
      .sum   (add_y),
      .c_out (add_c),
      .ovf   (add_v)
   );

   assign result    = kind.arith ? add_y : logic_y;
   assign result_we = ~kind.compare;

   alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
      .res         (result),
      .update      (upd),
      .arith       (kind.arith),
      .add_carry   (add_c),
      .add_ovf     (add_v),
      .shift_carry (shift_carry),
      .n_in        (flag_n_in),
      .z_in        (flag_z_in),
      .c_in        (flag_c_in),
      .v_in        (flag_v_in),
      .n_out       (flag_n_out),
      .z_out       (flag_z_out),
      .c_out       (flag_c_out),
      .v_out       (flag_v_out)
   );

   always_comb begin
      if (op_code[3:2] == 2'b10) begin
         a_r4_compare_no_write: assert (!result_we);
         a_r5_compare_sets_n: assert (flag_n_out == result[WIDTH-1]);
      end
      if (upd)
         a_r5_zero_flag: assert (flag_z_out == (result == '0));
   end

endmodule

// File: tb/tb_flag_alu.sv
`timescale 1ns/1ps
module tb_flag_alu;

   localparam int W = 32;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [3:0]   op_code = '0;
   logic [W-1:0] opnd_a = '0, opnd_b = '0;
   logic n_i = 0, z_i = 0, c_i = 0, v_i = 0, sc = 0, sf = 0;
   logic [W-1:0] result;
   logic we, n_o, z_o, c_o, v_o;

   int tests = 0, fails = 0;
   bit done = 0;

   flag_alu #(.WIDTH(W)) dut (
      .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .flag_n_in(n_i), .flag_z_in(z_i), .flag_c_in(c_i), .flag_v_in(v_i),
      .shift_carry(sc), .set_flags(sf),
      .result(result), .result_we(we),
      .flag_n_out(n_o), .flag_z_out(z_o), .flag_c_out(c_o), .flag_v_out(v_o)
   );

   // flags given as {n,z,c,v}
   task automatic run(input string tag, input logic [3:0] op,
                      input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [3:0] fin, input logic scar, input logic setf,
                      input logic [W-1:0] e_res, input logic e_we,
                      input logic [3:0] e_fl);
      @(negedge clk);
      op_code = op; opnd_a = a; opnd_b = b;
      {n_i, z_i, c_i, v_i} = fin; sc = scar; sf = setf;
      #1;
      tests++;
      if (result !== e_res || we !== e_we || {n_o, z_o, c_o, v_o} !== e_fl) begin
         fails++;
         $display("FAIL %s: res=%h we=%b nzcv=%b expected res=%h we=%b nzcv=%b",
                  tag, result, we, {n_o, z_o, c_o, v_o}, e_res, e_we, e_fl);
      end
   endtask

   task automatic t_reset_state();
      run("R9 idle", 4'b0000, '0, '0, 4'b0000, 0, 0, '0, 1, 4'b0000);
   endtask

   task automatic t_logical();
      run("R1 R8 and", 4'b0000, 32'hF0F0_1234, 32'h0FF0_FFFF, 4'b0001, 1, 1, 32'h00F0_1234, 1, 4'b0011);
      run("R1 R5 xor", 4'b0001, 32'hFFFF_0000, 32'h0000_FFFF, 4'b0000, 0, 1, 32'hFFFF_FFFF, 1, 4'b1000);
      run("R1 R9 or",  4'b1100, 32'h0000_0001, 32'h8000_0000, 4'b0111, 0, 0, 32'h8000_0001, 1, 4'b0111);
      run("R1 R5 bic", 4'b1110, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b1000, 0, 1, 32'h0, 1, 4'b0100);
      run("R1 pass",   4'b1101, 32'h1234_5678, 32'hCAFE_BABE, 4'b0000, 0, 0, 32'hCAFE_BABE, 1, 4'b0000);
      run("R1 R8 not", 4'b1111, 32'h0, 32'h0, 4'b0000, 1, 1, 32'hFFFF_FFFF, 1, 4'b1010);
   endtask

   task automatic t_arith();
      run("R7 add ovf",   4'b0100, 32'h7FFF_FFFF, 32'h1, 4'b0000, 0, 1, 32'h8000_0000, 1, 4'b1001);
      run("R6 add carry", 4'b0100, 32'hFFFF_FFFF, 32'h1, 4'b0000, 0, 1, 32'h0, 1, 4'b0110);
      run("R2 R6 sub borrow", 4'b0010, 32'd5, 32'd7, 4'b0000, 1, 1, 32'hFFFF_FFFE, 1, 4'b1000);
      run("R7 sub ovf",   4'b0010, 32'h8000_0000, 32'h1, 4'b0000, 0, 1, 32'h7FFF_FFFF, 1, 4'b0011);
      run("R2 rsb",       4'b0011, 32'd3, 32'd10, 4'b0000, 0, 1, 32'd7, 1, 4'b0010);
      run("R9 add noset", 4'b0100, 32'h7FFF_FFFF, 32'h1, 4'b0000, 1, 0, 32'h8000_0000, 1, 4'b0000);
   endtask

   task automatic t_carry_in();
      run("R3 adc",      4'b0101, 32'd1, 32'd2, 4'b0010, 0, 1, 32'd4, 1, 4'b0000);
      run("R3 sbc c0",   4'b0110, 32'd10, 32'd3, 4'b0000, 0, 1, 32'd6, 1, 4'b0010);
      run("R3 sbc c1",   4'b0110, 32'd10, 32'd3, 4'b0010, 0, 1, 32'd7, 1, 4'b0010);
      run("R3 rsc c0",   4'b0111, 32'd3, 32'd10, 4'b0000, 0, 1, 32'd6, 1, 4'b0010);
      run("R3 rsc c1",   4'b0111, 32'd10, 32'd3, 4'b0010, 0, 1, 32'hFFFF_FFF9, 1, 4'b1000);
   endtask

   task automatic t_compare();
      run("R4 csub eq",  4'b1010, 32'd5, 32'd5, 4'b0000, 0, 0, 32'h0, 0, 4'b0110);
      run("R4 cadd ovf", 4'b1011, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'b0000, 0, 0, 32'hFFFF_FFFE, 0, 4'b1001);
      run("R4 tand",     4'b1000, 32'hF0, 32'h0F, 4'b0001, 1, 0, 32'h0, 0, 4'b0111);
      run("R4 txor",     4'b1001, 32'h8000_0000, 32'h0, 4'b0110, 0, 0, 32'h8000_0000, 0, 4'b1000);
   endtask

   initial begin
      #1;
      t_reset_state();
      t_logical();
      t_arith();
      t_carry_in();
      t_compare();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         tests++;
         fails++;
         $display("FAIL watchdog: res=timeout expected res=completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule